// File: doc/BRIEF.md
# Branch Hazard Fetch Controller

This block is the fetch-side control for a five-stage in-order pipeline. It owns the fetch program counter and the valid bit and PC of the IF/ID pipeline register. It reacts to conditional branches that compare one register against zero. Each cycle the decoder presents the branch kind, the register value and the sign-extended word offset of the instruction held in IF/ID. The block then chooses the next fetch address, decides whether the IF/ID register takes a real instruction or a bubble, and raises a flush strobe when speculatively fetched work must be discarded.

An elaboration parameter picks one of two policies. In predict-not-taken mode the zero test and the target adder sit in ID. A branch that falls through costs nothing, and a taken branch costs one squashed slot. In stall mode the outcome is treated as known only late. Fetch freezes, and three bubbles enter ID behind every branch before the resolved instruction follows. A small state machine sequences the stall, with four states: ST_RUN, ST_HOLD1, ST_HOLD2 and ST_HOLD3. Its transitions are:
- ST_RUN to ST_HOLD1 when a valid branch sits in ID (stall mode only).
- ST_HOLD1 to ST_HOLD2 unconditionally.
- ST_HOLD2 to ST_HOLD3 unconditionally. This is the step that loads the resolved address.
- ST_HOLD3 back to ST_RUN unconditionally.

In predict-not-taken mode the machine never leaves ST_RUN.

Top module: `brh_fetch_ctl`

## Requirements
- R1: While reset is held, fetch_pc equals RESET_PC (0 by default), ifid_valid is 0 and flush is 0.
- R2: With no valid branch in ID, fetch_pc advances by 4 each cycle. IF/ID then captures a valid instruction, and its ifid_pc equals fetch_pc of the previous cycle.
- R3: Branch kind encoding: 2'b01 is taken when the register value is zero, 2'b10 is taken when it is nonzero, and 2'b00 and 2'b11 are not branches.
- R4: The taken target is ifid_pc + 4 + (sign-extended offset << 2). The fall-through address is ifid_pc + 4.
- R5: In predict-not-taken mode, a not-taken branch adds no bubble, and the instruction after it reaches ID in the next cycle.
- R6: In predict-not-taken mode, a taken branch raises flush in the cycle it is in ID. The next fetch_pc is the target, and exactly one bubble follows the branch.
- R7: Flush overrides a valid IF/ID load in the same cycle, so ifid_valid is 0 in the cycle after any flush.
- R8: In stall mode every valid branch is followed by exactly three bubbles in ID, and then by the resolved instruction. Flush is never raised in this mode.
- R9: Branch fields presented while ifid_valid is 0 have no effect: no flush, and fetch proceeds as for a non-branch.
- R10: In stall mode a not-taken branch resumes at the fall-through address, and a taken one at the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| br_kind | input | 2 | Branch kind of the instruction in IF/ID (see R3) |
| br_rs | input | ADDR_W | Register value read in ID for the zero test |
| br_off | input | OFF_W | Word offset of the branch, sign extended inside |
| fetch_pc | output | ADDR_W | Address fetched this cycle |
| ifid_valid | output | 1 | IF/ID holds a real instruction (0 = bubble) |
| ifid_pc | output | ADDR_W | PC of the instruction in IF/ID |
| flush | output | 1 | Discards the instruction being loaded into IF/ID |

## Verification
The flush and the normal IF/ID load coincide whenever a taken branch sits in ID in predict-not-taken mode, because the fall-through instruction is being captured in the same cycle. Taken branches, including a zero offset whose target equals the fall-through address, provoke this collision. It is judged by ifid_valid reading 0 on the next cycle, with fetch_pc at the target. In stall mode the hold of fetch coincides with the zero-test capture. Per-branch bubble counts measured at the ports are compared against 3, 1 or 0, and a random instruction table mixes back-to-back and self-aliasing branches with directed ones.

// File: rtl/brh_pkg.sv
package brh_pkg;

    typedef enum logic [1:0] {
        BK_NONE    = 2'b00,
        BK_ZERO    = 2'b01,
        BK_NONZERO = 2'b10,
        BK_RSVD    = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_HOLD1 = 2'b01,
        ST_HOLD2 = 2'b10,
        ST_HOLD3 = 2'b11
    } fe_state_e;

endpackage

// File: rtl/brh_resolve.sv
module brh_resolve
    import brh_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] rs_val,
    input  logic [OFF_W-1:0]  off,
    input  logic [ADDR_W-1:0] pc,
    output logic              is_branch,
    output logic              taken,
    output logic [ADDR_W-1:0] seq_pc,
    output logic [ADDR_W-1:0] tgt_pc
);
    localparam int EXT_W = ADDR_W - OFF_W - 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic              rs_zero;
    logic [ADDR_W-1:0] disp;

    assign rs_zero = (rs_val == '0);
    assign disp    = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};

    always_comb begin
        is_branch = 1'b0;
        taken     = 1'b0;
        unique case (br_kind_e'(kind))
            BK_ZERO: begin
                is_branch = 1'b1;
                taken     = rs_zero;
            end
            BK_NONZERO: begin
                is_branch = 1'b1;
                taken     = !rs_zero;
            end
            BK_NONE, BK_RSVD: begin
                is_branch = 1'b0;
                taken     = 1'b0;
            end
            default: begin
                is_branch = 1'b0;
                taken     = 1'b0;
            end
        endcase
    end

    // dedicated adder in ID, independent of the execute ALU
    assign seq_pc = pc + STEP;
    assign tgt_pc = seq_pc + disp;

endmodule

// File: rtl/brh_ifid_reg.sv
module brh_ifid_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic              squash,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              ifid_valid,
    output logic [ADDR_W-1:0] ifid_pc
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ifid_valid <= 1'b0;
            ifid_pc    <= '0;
        end else begin
            ifid_pc <= fetch_pc;
            if (squash) begin
                ifid_valid <= 1'b0;
            end else begin
                ifid_valid <= load_valid;
            end
        end
    end
endmodule

// File: rtl/brh_fetch_fsm.sv
module brh_fetch_fsm
    import brh_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0,
    parameter int              PREDICT_NT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_hit,
    input  logic              taken,
    input  logic [ADDR_W-1:0] seq_pc,
    input  logic [ADDR_W-1:0] tgt_pc,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              load_valid,
    output logic              squash
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    fe_state_e         state, state_n;
    logic [ADDR_W-1:0] pc_n;
    logic [ADDR_W-1:0] saved_pc;
    logic              save_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_n;
        end
    end

    // next-state and outputs
    always_comb begin
        state_n    = state;
        pc_n       = fetch_pc + STEP;
        load_valid = 1'b1;
        squash     = 1'b0;
        save_en    = 1'b0;
        unique case (state)
            ST_RUN: begin
                if (br_hit) begin
                    if (PREDICT_NT != 0) begin
                        if (taken) begin
                            squash = 1'b1;
                            pc_n   = tgt_pc;
                        end
                    end else begin
                        load_valid = 1'b0;
                        pc_n       = fetch_pc;
                        save_en    = 1'b1;
                        state_n    = ST_HOLD1;
                    end
                end
            end
            ST_HOLD1: begin
                load_valid = 1'b0;
                pc_n       = fetch_pc;
                state_n    = ST_HOLD2;
            end
            ST_HOLD2: begin
                load_valid = 1'b0;
                pc_n       = saved_pc;
                state_n    = ST_HOLD3;
            end
            ST_HOLD3: begin
                state_n = ST_RUN;
            end
            default: begin
                state_n = ST_RUN;
            end
        endcase
    end

    // fetch address and late-resolved redirect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_pc <= RESET_PC;
            saved_pc <= '0;
        end else begin
            fetch_pc <= pc_n;
            if (save_en) begin
                saved_pc <= taken ? tgt_pc : seq_pc;
            end
        end
    end

endmodule

// File: rtl/brh_fetch_ctl.sv
module brh_fetch_ctl
    import brh_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                OFF_W      = 16,
    parameter logic [ADDR_W-1:0] RESET_PC   = '0,
    parameter int                PREDICT_NT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        br_kind,
    input  logic [ADDR_W-1:0] br_rs,
    input  logic [OFF_W-1:0]  br_off,
    output logic [ADDR_W-1:0] fetch_pc,
    output logic              ifid_valid,
    output logic [ADDR_W-1:0] ifid_pc,
    output logic              flush
);
    logic              is_branch;
    logic              taken;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] tgt_pc;
    logic              br_hit;
    logic              load_valid;

    brh_resolve #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_resolve (
        .kind      (br_kind),
        .rs_val    (br_rs),
        .off       (br_off),
        .pc        (ifid_pc),
        .is_branch (is_branch),
        .taken     (taken),
        .seq_pc    (seq_pc),
        .tgt_pc    (tgt_pc)
    );

    assign br_hit = ifid_valid && is_branch;

    brh_fetch_fsm #(
        .ADDR_W     (ADDR_W),
        .RESET_PC   (RESET_PC),
        .PREDICT_NT (PREDICT_NT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .br_hit     (br_hit),
        .taken      (taken),
        .seq_pc     (seq_pc),
        .tgt_pc     (tgt_pc),
        .fetch_pc   (fetch_pc),
        .load_valid (load_valid),
        .squash     (flush)
    );

    brh_ifid_reg #(.ADDR_W(ADDR_W)) u_ifid (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (load_valid),
        .squash     (flush),
        .fetch_pc   (fetch_pc),
        .ifid_valid (ifid_valid),
        .ifid_pc    (ifid_pc)
    );

endmodule

// File: rtl/brh_fetch_ctl_chk.sv
module brh_fetch_ctl_chk #(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int PREDICT_NT = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        br_kind,
    input logic [ADDR_W-1:0] br_rs,
    input logic [OFF_W-1:0]  br_off,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              ifid_valid,
    input logic [ADDR_W-1:0] ifid_pc,
    input logic              flush
);
    localparam int EXT_W = ADDR_W - OFF_W - 2;
    localparam logic [2:0] MAX_BUB = (PREDICT_NT != 0) ? 3'd1 : 3'd3;

    logic [2:0] zrun;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zrun <= '0;
        end else if (ifid_valid) begin
            zrun <= '0;
        end else if (zrun != 3'd7) begin
            zrun <= zrun + 3'd1;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !ifid_valid && !flush); // R1
    AST_IFID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ifid_pc == $past(fetch_pc)); // R2
    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (flush && br_kind == 2'b01) |-> br_rs == '0); // R3
    AST_FLUSH_TARGET: assert property (@(posedge clk) disable iff (!rst_n) flush |=> fetch_pc == $past(ifid_pc) + ADDR_W'(4) + {{EXT_W{$past(br_off[OFF_W-1])}}, $past(br_off), 2'b00}); // R4
    AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !ifid_valid); // R7
    AST_FLUSH_VALID: assert property (@(posedge clk) disable iff (!rst_n) flush |-> ifid_valid); // R9
    AST_BUBBLE_RUN: assert property (@(posedge clk) disable iff (!rst_n) zrun <= MAX_BUB); // R8

    generate
        if (PREDICT_NT != 0) begin : g_pnt
            AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n) !flush |=> fetch_pc == $past(fetch_pc) + ADDR_W'(4)); // R5
        end else begin : g_stall
            AST_NO_FLUSH_STALL: assert property (@(posedge clk) disable iff (!rst_n) !flush); // R8
        end
    endgenerate

endmodule

bind brh_fetch_ctl brh_fetch_ctl_chk #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .PREDICT_NT (PREDICT_NT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_kind    (br_kind),
    .br_rs      (br_rs),
    .br_off     (br_off),
    .fetch_pc   (fetch_pc),
    .ifid_valid (ifid_valid),
    .ifid_pc    (ifid_pc),
    .flush      (flush)
);

// File: tb/brh_fetch_ctl_test.sv
module brh_fetch_ctl_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // instruction table indexed by pc[7:2]
    logic [1:0]  t_kind [64];
    logic [31:0] t_rs   [64];
    logic [15:0] t_off  [64];

    logic [31:0] d_pc   [2];
    logic        d_v    [2];
    logic [31:0] d_ipc  [2];
    logic        d_fl   [2];

    brh_fetch_ctl #(.PREDICT_NT(1)) uut (
        .clk(clk), .rst_n(rst_n),
        .br_kind(t_kind[d_ipc[0][7:2]]), .br_rs(t_rs[d_ipc[0][7:2]]), .br_off(t_off[d_ipc[0][7:2]]),
        .fetch_pc(d_pc[0]), .ifid_valid(d_v[0]), .ifid_pc(d_ipc[0]), .flush(d_fl[0])
    );

    brh_fetch_ctl #(.PREDICT_NT(0)) uut_stall (
        .clk(clk), .rst_n(rst_n),
        .br_kind(t_kind[d_ipc[1][7:2]]), .br_rs(t_rs[d_ipc[1][7:2]]), .br_off(t_off[d_ipc[1][7:2]]),
        .fetch_pc(d_pc[1]), .ifid_valid(d_v[1]), .ifid_pc(d_ipc[1]), .flush(d_fl[1])
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // model state: index 0 predict-not-taken, 1 stall
    logic [31:0] e_pc [2];
    logic        e_v  [2];
    logic [31:0] e_ipc[2];
    logic [31:0] e_sv [2];
    int          e_wait[2];
    bit          b_seen[2];
    int          b_cnt [2];
    int          b_exp [2];
    string       b_req [2];

    function automatic bit f_isbr(input logic [1:0] k);
        return (k == 2'b01) || (k == 2'b10);
    endfunction

    function automatic bit f_taken(input logic [1:0] k, input logic [31:0] rs);
        if (k == 2'b01) return rs == 32'd0;
        if (k == 2'b10) return rs != 32'd0;
        return 1'b0;
    endfunction

    function automatic logic [31:0] f_tgt(input logic [31:0] pc, input logic [15:0] off);
        return pc + 32'd4 + {{14{off[15]}}, off, 2'b00};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int m = 0; m < 2; m++) begin
            e_pc[m] = 32'd0; e_v[m] = 1'b0; e_ipc[m] = 32'd0;
            e_sv[m] = 32'd0; e_wait[m] = 0; b_seen[m] = 0; b_cnt[m] = 0;
        end
    endtask

    // called away from the clock edge: compare, then advance the model
    task automatic cycle();
        for (int m = 0; m < 2; m++) begin
            logic [5:0]  ix  = e_ipc[m][7:2];
            bit          br  = f_isbr(t_kind[ix]);
            bit          tk  = f_taken(t_kind[ix], t_rs[ix]);
            logic [31:0] tg  = f_tgt(e_ipc[m], t_off[ix]);
            bit          hit = e_v[m] && br && (e_wait[m] == 0);
            bit          efl = (m == 0) && hit && tk;
            string       rq;
            if (e_wait[m] != 0) rq = "R8";
            else if (!e_v[m] && br) rq = "R9";
            else rq = "R2";
            chk(rq, d_pc[m], e_pc[m]);
            chk(rq, {31'd0, d_v[m]}, {31'd0, e_v[m]});
            chk(rq, d_ipc[m], e_ipc[m]);
            chk(efl ? "R3" : (m == 1 ? "R8" : rq), {31'd0, d_fl[m]}, {31'd0, efl});

            // bubble accounting from the ports
            if (b_seen[m]) begin
                if (!d_v[m]) b_cnt[m]++;
                else begin
                    chk(b_req[m], b_cnt[m], b_exp[m]);
                    b_seen[m] = 0;
                end
            end
            if (d_v[m] && f_isbr(t_kind[d_ipc[m][7:2]])) begin
                bit t2 = f_taken(t_kind[d_ipc[m][7:2]], t_rs[d_ipc[m][7:2]]);
                b_seen[m] = 1; b_cnt[m] = 0;
                b_exp[m] = (m == 1) ? 3 : (t2 ? 1 : 0);
                b_req[m] = (m == 1) ? (t2 ? "R8" : "R10") : (t2 ? "R6" : "R5");
            end

            // advance the model one edge
            if (m == 0) begin
                e_ipc[m] = e_pc[m];
                if (hit && tk) begin e_pc[m] = tg; e_v[m] = 1'b0; end
                else begin e_pc[m] = e_pc[m] + 32'd4; e_v[m] = 1'b1; end
            end else begin
                e_ipc[m] = e_pc[m];
                case (e_wait[m])
                    0: if (hit) begin
                           e_sv[m] = tk ? tg : e_pc[m];
                           e_v[m] = 1'b0; e_wait[m] = 3;
                       end else begin
                           e_pc[m] = e_pc[m] + 32'd4; e_v[m] = 1'b1;
                       end
                    3: begin e_v[m] = 1'b0; e_wait[m] = 2; end
                    2: begin e_v[m] = 1'b0; e_pc[m] = e_sv[m]; e_wait[m] = 1; end
                    default: begin e_v[m] = 1'b1; e_pc[m] = e_pc[m] + 32'd4; e_wait[m] = 0; end
                endcase
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            chk("R1", d_pc[m], 32'd0);
            chk("R1", {31'd0, d_v[m]}, 32'd0);
            chk("R1", {31'd0, d_fl[m]}, 32'd0);
        end
        model_reset();
        rst_n = 1'b1;
        cycle();
    endtask

    task automatic fill_directed();
        for (int i = 0; i < 64; i++) begin
            t_kind[i] = 2'b00; t_rs[i] = 32'd3; t_off[i] = 16'd0;
        end
        t_kind[0] = 2'b01; t_rs[0] = 32'd0; t_off[0] = 16'd0;      // taken, target = fall-through
        t_kind[1] = 2'b01; t_rs[1] = 32'd0; t_off[1] = 16'd3;      // pc 4 -> 20
        t_kind[5] = 2'b10; t_rs[5] = 32'd7; t_off[5] = 16'd1;      // pc 20 -> 28
        t_kind[7] = 2'b01; t_rs[7] = 32'd9; t_off[7] = 16'd5;      // not taken
        t_kind[8] = 2'b10; t_rs[8] = 32'd0; t_off[8] = 16'd5;      // back-to-back, not taken
        t_kind[9] = 2'b10; t_rs[9] = 32'd1; t_off[9] = 16'hFFF6;   // pc 36 -> 0 (R4 negative)
        t_kind[2] = 2'b11; t_rs[2] = 32'd0; t_off[2] = 16'd4;      // reserved kind: not a branch
    endtask

    task automatic fill_random();
        for (int i = 0; i < 64; i++) begin
            int so;
            t_kind[i] = 2'($urandom);
            t_rs[i]   = ($urandom % 2 == 0) ? 32'd0 : $urandom;
            so        = int'($urandom % 41) - 20;
            t_off[i]  = 16'(so);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20517));
        fill_directed();
        do_reset();
        repeat (80) begin @(negedge clk); cycle(); end
        fill_random();
        do_reset();
        repeat (4000) begin @(negedge clk); cycle(); end
        fill_random();
        do_reset();
        repeat (4000) begin @(negedge clk); cycle(); end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule